// File: doc/BRIEF.md
# Converter Result Stability Filter

This block sits between the result stream of an analog-to-digital converter and a status byte that the rest of the chip reads. Every accepted conversion result is a candidate for the status. With filtering on, the status takes a new value only after a run of consecutive results agrees on its upper bits. The two least significant bits take no part in this comparison. With filtering off, every accepted result goes straight to the status.

Results arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle, so a result is taken on any rising clock edge where `in_valid` is high. Cycles without `in_valid` are gaps. They neither advance nor break a run. The `filter_off` pin is a plain configuration level. Any change of its value restarts the run.

Top module: `adc_stability_filter`

## Requirements
- R1: While `rst_n` is low and after its release, `status` is 0 and `status_load` is 0 until a result is accepted. Reset also empties the run.
- R2: `in_ready` is always 1. A result is accepted on every rising edge where `in_valid` is 1.
- R3: With `filter_off` = 0, the fourth consecutive accepted result whose bits [7:2] equal those of the three before it has the following effect at its accepting edge: `status` is loaded with `in_data[7:2]` and `status_load` is high for the next cycle.
- R4: Bits [1:0] of `in_data` are ignored when results are compared and are never stored. For example, 8'hA4, A5, A6 and A7 count as one value, and the status they load is 6'h29.
- R5: An accepted result whose bits [7:2] differ from the current candidate makes it the new candidate and restarts the run at a length of 1.
- R6: Once a run has loaded the status, further equal results load nothing more (`status_load` stays 0) until the run restarts.
- R7: With `filter_off` = 1, every accepted result loads `in_data[7:2]` into `status` and pulses `status_load`, even if the value is unchanged.
- R8: An edge in which `filter_off` differs from its value at the previous edge restarts the run. A result accepted in that edge counts as the first of the new run.
- R9: Idle cycles (`in_valid` = 0) neither advance nor break a run.
- R10: `status` changes only in a cycle in which `status_load` is 1. `status_load` is 1 only after an edge that accepted a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Conversion result present on `in_data` |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| in_data | input | 8 | Conversion result |
| filter_off | input | 1 | 1 = every result updates the status; 0 = wait for a stable run |
| status | output | 6 | Held upper bits of the last accepted result |
| status_load | output | 1 | One-cycle strobe in the cycle the status is loaded |

## Verification
The filtered path gets several input patterns. Runs differing only in the low bits show whether the comparison masks them. A run broken by a different value at position four shows whether a restart begins at one or at zero. Gaps inside a run show that idle cycles are neutral. A long equal run after a load shows the saturation. Toggling the mode during a partial run and then finishing it tells a restarted count apart from a resumed one. Repeated equal values in bypass show that every result pulses the strobe. A random mix of gaps, near-equal values and mode flips is compared against the reference on every clock.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  // What the run tracker does with the current edge
  typedef enum logic [2:0] {
    ACT_IDLE,     // nothing accepted, mode unchanged
    ACT_CLEAR,    // drop run (mode change without data, or bypass)
    ACT_RESTART,  // new candidate, run length 1
    ACT_ADVANCE,  // same candidate, run length + 1
    ACT_HOLD      // saturated, no further load
  } run_act_e;
endpackage

// File: rtl/sfx_mode_watch.sv
module sfx_mode_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic filter_off,
  output logic mode_change
);
  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= filter_off;
  end

  assign mode_change = filter_off ^ mode_q;
endmodule

// File: rtl/sfx_run_tracker.sv
module sfx_run_tracker
  import sfx_pkg::*;
#(
  parameter int KEEP_W    = 6,
  parameter int MATCH_RUN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              bypass,
  input  logic              restart_req,
  input  logic [KEEP_W-1:0] key,
  output logic              commit
);
  localparam int CNT_W = $clog2(MATCH_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(MATCH_RUN);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(MATCH_RUN - 1);

  logic [KEEP_W-1:0] cand_q;
  logic [CNT_W-1:0]  cnt_q;
  run_act_e          act;
  logic              restart_commits;

  generate
    if (MATCH_RUN == 1) begin : g_single
      assign restart_commits = 1'b1;
    end else begin : g_multi
      assign restart_commits = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!accept)
      act = restart_req ? ACT_CLEAR : ACT_IDLE;
    else if (bypass)
      act = ACT_CLEAR;
    else if (restart_req || cnt_q == '0 || key != cand_q)
      act = ACT_RESTART;
    else if (cnt_q == RUN_MAX)
      act = ACT_HOLD;
    else
      act = ACT_ADVANCE;
  end

  always_comb begin
    commit = 1'b0;
    if (accept) begin
      if (bypass)                                       commit = 1'b1;
      else if (act == ACT_RESTART)                      commit = restart_commits;
      else if (act == ACT_ADVANCE && cnt_q == RUN_LAST) commit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (act)
        ACT_CLEAR:   cnt_q <= '0;
        ACT_RESTART: begin
          cand_q <= key;
          cnt_q  <= CNT_W'(1);
        end
        ACT_ADVANCE: cnt_q <= cnt_q + CNT_W'(1);
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/sfx_status_hold.sv
module sfx_status_hold #(
  parameter int KEEP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [KEEP_W-1:0] key,
  output logic [KEEP_W-1:0] status,
  output logic              status_load
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status      <= '0;
      status_load <= 1'b0;
    end else begin
      status_load <= commit;
      if (commit) status <= key;
    end
  end
endmodule

// File: rtl/adc_stability_filter.sv
module adc_stability_filter #(
  parameter int DATA_W    = 8,
  parameter int KEEP_W    = 6,
  parameter int MATCH_RUN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              filter_off,
  output logic [KEEP_W-1:0] status,
  output logic              status_load
);
  logic              accept;
  logic              mode_change;
  logic              commit;
  logic [KEEP_W-1:0] key;

  assign in_ready = 1'b1;
  assign accept   = in_valid;
  assign key      = in_data[DATA_W-1 -: KEEP_W];

  sfx_mode_watch u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .filter_off  (filter_off),
    .mode_change (mode_change)
  );

  sfx_run_tracker #(.KEEP_W(KEEP_W), .MATCH_RUN(MATCH_RUN)) u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .bypass      (filter_off),
    .restart_req (mode_change),
    .key         (key),
    .commit      (commit)
  );

  sfx_status_hold #(.KEEP_W(KEEP_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .key         (key),
    .status      (status),
    .status_load (status_load)
  );
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker #(
  parameter int DATA_W = 8,
  parameter int KEEP_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              filter_off,
  input logic [KEEP_W-1:0] status,
  input logic              status_load
);
  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R10
  status_moves_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> status_load);

  // R10
  no_load_without_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !status_load);

  // R7
  bypass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_off && in_valid) |=> status_load);

  // R7
  bypass_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_off && in_valid) |=> status == $past(in_data[DATA_W-1 -: KEEP_W]));

  // R6
  saturate_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_load && !filter_off && !$past(filter_off) && in_valid &&
     in_data[DATA_W-1 -: KEEP_W] == status) |=> !status_load);
endmodule

bind adc_stability_filter sfx_checker #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .filter_off  (filter_off),
  .status      (status),
  .status_load (status_load)
);

// File: tb/sim_adc_stability_filter.sv
`timescale 1ns/1ps
module sim_adc_stability_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       filter_off = 1'b0;
  logic       in_ready;
  logic [5:0] status;
  logic       status_load;

  int    checks = 0;
  int    failures = 0;
  bit    reported = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  adc_stability_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .filter_off(filter_off),
    .status(status), .status_load(status_load)
  );

  // Behavioural reference: history of kept values since the last restart
  int         hist[$];
  logic [5:0] m_status = '0;
  bit         m_load = 1'b0;
  bit         m_prev_mode = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); m_status = '0; m_load = 1'b0; m_prev_mode = 1'b0;
    end else begin
      m_load = 1'b0;
      if (filter_off != m_prev_mode) hist.delete();
      m_prev_mode = filter_off;
      if (in_valid) begin
        if (filter_off) begin
          hist.delete();
          m_status = in_data[7:2];
          m_load   = 1'b1;
        end else begin
          int tail;
          hist.push_back(int'(in_data[7:2]));
          if (hist.size() > 8) void'(hist.pop_front());
          tail = 0;
          for (int i = hist.size() - 1; i >= 0; i--) begin
            if (hist[i] == hist[hist.size()-1]) tail++;
            else break;
          end
          if (tail == 4) begin
            m_status = in_data[7:2];
            m_load   = 1'b1;
          end
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !reported) begin
      check(phase, int'(status), int'(m_status));
      check(phase, int'(status_load), int'(m_load));
    end
  end

  task automatic send(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(status), 0);
    check("R1", int'(status_load), 0);
    rst_n = 1'b1;
    idle(2);
    check("R1", int'(status), 0);
    check("R2", int'(in_ready), 1);

    // R3 / R4: four results equal in bits 7:2, different low bits
    phase = "R4";
    send(8'hA4); send(8'hA5); send(8'hA6);
    check("R4", int'(status_load), 0);
    phase = "R3";
    send(8'hA7);
    check("R3", int'(status), 'h29);
    check("R3", int'(status_load), 1);

    // R6: saturation
    phase = "R6";
    send(8'hA4);
    check("R6", int'(status_load), 0);
    send(8'hA4); send(8'hA4);
    check("R6", int'(status), 'h29);

    // R5: break at position four restarts at one
    phase = "R5";
    send(8'h10); send(8'h10); send(8'h10); send(8'h20);
    check("R5", int'(status), 'h29);
    send(8'h20); send(8'h20);
    check("R5", int'(status_load), 0);
    send(8'h20);
    check("R5", int'(status), 'h08);
    check("R5", int'(status_load), 1);

    // R9: gaps inside a run
    phase = "R9";
    send(8'h30); idle(3); send(8'h31); idle(1); send(8'h32);
    check("R9", int'(status), 'h08);
    idle(2); send(8'h33);
    check("R9", int'(status), 'h0C);
    check("R9", int'(status_load), 1);

    // R8: mode toggle during a partial run restarts it
    phase = "R8";
    send(8'h40); send(8'h40); send(8'h40);
    filter_off = 1'b1; idle(1);
    filter_off = 1'b0; idle(1);
    send(8'h40);
    check("R8", int'(status), 'h0C);
    check("R8", int'(status_load), 0);
    send(8'h40); send(8'h40); send(8'h40);
    check("R8", int'(status), 'h10);
    check("R8", int'(status_load), 1);

    // R7: bypass loads every result
    phase = "R7";
    filter_off = 1'b1;
    send(8'h50);
    check("R7", int'(status), 'h14);
    check("R7", int'(status_load), 1);
    send(8'h50);
    check("R7", int'(status_load), 1);
    send(8'h93);
    check("R7", int'(status), 'h24);
    idle(1);
    check("R10", int'(status_load), 0);
    filter_off = 1'b0;
    idle(1);

    // Mixed random traffic against the reference (R10)
    phase = "R10";
    for (int n = 0; n < 3000; n++) begin
      in_valid = ($urandom_range(0, 3) != 0);
      in_data  = {1'b0, 3'($urandom_range(0, 2)), 2'b0, 2'($urandom)};
      if ($urandom_range(0, 60) == 0) filter_off = ~filter_off;
      @(negedge clk);
    end
    in_valid = 1'b0;
    idle(2);

    report();
    $finish;
  end
endmodule